// File: doc/BRIEF.md
# Dual-Byte 8b/10b Transmit Serializer

This block takes a 16-bit parallel word plus one control flag per byte, codes each byte into a 10-bit line character, and sends the two characters out as a single 20-bit serial word, one bit per bit-clock enable. The low byte (word bits 7..0) is coded first. Its ending running disparity feeds the high byte (bits 15..8). The high byte's ending disparity is then carried to the low byte of the next word, so the line stays DC-balanced across byte and word boundaries.

The block runs on one bit clock, gated by `bit_en`, which stands in for the clock multiplier. An internal phase counter marks one enabled edge in every twenty as the word slot and shows it on `word_take`. The source holds the word steady while `word_take` is high, and the word is latched on the next enabled edge. Coding happens part-way through the following word period. The result enters a 20-bit shift register at the next slot and then passes through a fixed retiming line, so the latency from capture to the first serial bit never changes.

When a control flag is set on a byte value that is not a legal control character, the byte is coded as ordinary data and a sticky error flag goes high.

Top module: `dual_byte_serializer`

## Requirements
- R1: Data and flags are latched only on an enabled edge where `word_take` is high. Input values at any other time have no effect on the serial stream.
- R2: `tx_word[7:0]` is coded under `tx_ctl[0]` and `tx_word[15:8]` under `tx_ctl[1]`. A flag value of 1 selects a control character and 0 selects a data character, so all four flag combinations are legal.
- R3: Data characters follow the standard 5b/6b and 3b/4b code tables. The alternate x.7 sub-block is used when the running disparity is negative and x is 17, 18 or 20, and when it is positive and x is 11, 13 or 14. The serial line never carries more than five equal bits in a row.
- R4: Legal control characters are K28.0 to K28.7 (byte values 0x1C, 0x3C, ..., 0xFC), K23.7 (0xF7), K27.7 (0xFB), K29.7 (0xFD) and K30.7 (0xFE). Each is coded with its standard control form.
- R5: Running disparity is negative after reset. The high byte is coded with the disparity left by the low byte, and the next word's low byte is coded with the disparity left by the high byte.
- R6: Each word leaves as 20 bits, one per enabled edge. The low character goes first, then the high character. Each character is sent in the order a, b, c, d, e, i, f, g, h, j.
- R7: The first serial bit of a word appears on `ser_out` exactly WORD_BITS+OUT_DLY enabled edges (36 by default) after its capture edge. While `bit_en` is low, `ser_out` and `word_take` hold their values.
- R8: During reset, `ser_out`, `word_take` and `k_err` are 0. The first word sent after reset is the pair K28.5/K28.5, and its first bit appears after the 36th enabled edge.
- R9: A set flag on an illegal control value makes that byte's character the data coding of the same value. `k_err` rises on the edge where that word is coded and stays high until reset.
- R10: `word_take` is high on exactly one enabled edge out of every 20, and falls after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-rate enable; every register advances only when high |
| tx_word | input | 16 | Parallel word; bits 7..0 are the low byte |
| tx_ctl | input | 2 | Per-byte control flags; bit 0 for the low byte, bit 1 for the high byte |
| word_take | output | 1 | The next enabled edge latches `tx_word` and `tx_ctl` |
| ser_out | output | 1 | Serial line bit |
| k_err | output | 1 | Sticky flag for an illegal control value |

## Verification
The bench targets several corner cases in turn:
- D.x.7 bytes at both disparities and the alternate-x.7 trigger values. An encoder with a wrong disparity rule or a wrong alternate choice emits a character that breaks the expected bit stream or creates a six-bit run.
- Every legal control character under all four flag pairs. A design that swaps byte lanes, reverses bit order, or drops the disparity carry between the two bytes shows up at once on the serial line.
- Randomly gapped `bit_en`. A design that advances or changes its output on a disabled cycle loses alignment or moves `ser_out` while frozen.
- An illegal control value. This must give a data character plus a flag that never falls.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

   localparam int unsigned BYTE_BITS = 8;
   localparam int unsigned SYM_BITS  = 10;

   typedef logic [SYM_BITS-1:0] sym_t;

   // Line character that the input register holds after reset (K28.5).
   localparam logic [BYTE_BITS-1:0] IDLE_BYTE = 8'hBC;

endpackage

// File: rtl/dbs_byte_enc.sv
module dbs_byte_enc
   import dbs_pkg::*;
(
   input  logic [BYTE_BITS-1:0] byte_i,
   input  logic                 k_i,
   input  logic                 rd_i,      // 0 = negative, 1 = positive
   output sym_t                 sym_o,     // bit 0 leaves the wire first
   output logic                 rd_o,
   output logic                 k_bad_o
);

   logic [4:0] x_v;
   logic [2:0] y_v;
   logic       k_ok, k28;
   logic       two6, flip6, rd_mid;
   logic [5:0] c6, s6;
   logic       two4, alt7;
   logic [3:0] c4, s4;
   logic [9:0] msb_first;

   always_comb begin
      x_v = byte_i[4:0];
      y_v = byte_i[7:5];

      k_ok = k_i && ((x_v == 5'd28) ||
                     ((y_v == 3'd7) && (x_v == 5'd23 || x_v == 5'd27 ||
                                        x_v == 5'd29 || x_v == 5'd30)));
      k28  = k_ok && (x_v == 5'd28);

      // {has two forms, negative-disparity form as abcdei}
      case (x_v)
         5'd0:  {two6, c6} = {1'b1, 6'b100111};
         5'd1:  {two6, c6} = {1'b1, 6'b011101};
         5'd2:  {two6, c6} = {1'b1, 6'b101101};
         5'd3:  {two6, c6} = {1'b0, 6'b110001};
         5'd4:  {two6, c6} = {1'b1, 6'b110101};
         5'd5:  {two6, c6} = {1'b0, 6'b101001};
         5'd6:  {two6, c6} = {1'b0, 6'b011001};
         5'd7:  {two6, c6} = {1'b1, 6'b111000};
         5'd8:  {two6, c6} = {1'b1, 6'b111001};
         5'd9:  {two6, c6} = {1'b0, 6'b100101};
         5'd10: {two6, c6} = {1'b0, 6'b010101};
         5'd11: {two6, c6} = {1'b0, 6'b110100};
         5'd12: {two6, c6} = {1'b0, 6'b001101};
         5'd13: {two6, c6} = {1'b0, 6'b101100};
         5'd14: {two6, c6} = {1'b0, 6'b011100};
         5'd15: {two6, c6} = {1'b1, 6'b010111};
         5'd16: {two6, c6} = {1'b1, 6'b011011};
         5'd17: {two6, c6} = {1'b0, 6'b100011};
         5'd18: {two6, c6} = {1'b0, 6'b010011};
         5'd19: {two6, c6} = {1'b0, 6'b110010};
         5'd20: {two6, c6} = {1'b0, 6'b001011};
         5'd21: {two6, c6} = {1'b0, 6'b101010};
         5'd22: {two6, c6} = {1'b0, 6'b011010};
         5'd23: {two6, c6} = {1'b1, 6'b111010};
         5'd24: {two6, c6} = {1'b1, 6'b110011};
         5'd25: {two6, c6} = {1'b0, 6'b100110};
         5'd26: {two6, c6} = {1'b0, 6'b010110};
         5'd27: {two6, c6} = {1'b1, 6'b110110};
         5'd28: {two6, c6} = {1'b0, 6'b001110};
         5'd29: {two6, c6} = {1'b1, 6'b101110};
         5'd30: {two6, c6} = {1'b1, 6'b011110};
         default: {two6, c6} = {1'b1, 6'b101011};
      endcase
      if (k28) {two6, c6} = {1'b1, 6'b001111};

      // x.7 data has two balanced forms; every other two-form code is unbalanced
      flip6  = two6 && !((x_v == 5'd7) && !k28);
      s6     = (rd_i && two6) ? ~c6 : c6;
      rd_mid = rd_i ^ flip6;

      alt7 = (y_v == 3'd7) &&
             (k_ok ||
              (!rd_mid && (x_v == 5'd17 || x_v == 5'd18 || x_v == 5'd20)) ||
              ( rd_mid && (x_v == 5'd11 || x_v == 5'd13 || x_v == 5'd14)));

      case (y_v)
         3'd0:    {two4, c4} = {1'b1, 4'b1011};
         3'd1:    {two4, c4} = {1'b0, 4'b1001};
         3'd2:    {two4, c4} = {1'b0, 4'b0101};
         3'd3:    {two4, c4} = {1'b1, 4'b1100};
         3'd4:    {two4, c4} = {1'b1, 4'b1101};
         3'd5:    {two4, c4} = {1'b0, 4'b1010};
         3'd6:    {two4, c4} = {1'b0, 4'b0110};
         default: {two4, c4} = {1'b1, (alt7 ? 4'b0111 : 4'b1110)};
      endcase

      s4 = c4;
      if (two4 && rd_mid)
         s4 = ~c4;
      else if (k28 && !two4 && !rd_mid)
         s4 = ~c4;

      rd_o    = rd_mid ^ (two4 && (y_v != 3'd3));
      k_bad_o = k_i && !k_ok;

      msb_first = {s6, s4};
      for (int i = 0; i < SYM_BITS; i++)
         sym_o[i] = msb_first[SYM_BITS-1-i];
   end

endmodule

// File: rtl/dbs_phase.sv
module dbs_phase #(
   parameter int unsigned WORD_BITS = 20,
   parameter int unsigned ENC_PH    = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   output logic take_o,
   output logic enc_o
);

   localparam int unsigned CW = $clog2(WORD_BITS);
   localparam logic [CW-1:0] LAST  = CW'(WORD_BITS - 1);
   localparam logic [CW-1:0] ENC_V = CW'(ENC_PH);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (bit_en)
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
   end

   assign take_o = rst_n && (cnt_q == LAST);
   assign enc_o  = (cnt_q == ENC_V);

endmodule

// File: rtl/dbs_shift.sv
module dbs_shift #(
   parameter int unsigned WORD_BITS = 20,
   parameter int unsigned OUT_DLY   = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bit_en,
   input  logic                 load_i,
   input  logic [WORD_BITS-1:0] word_i,
   output logic                 ser_o
);

   logic [WORD_BITS-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sh_q <= '0;
      else if (bit_en) begin
         if (load_i)
            sh_q <= word_i;
         else
            sh_q <= {1'b0, sh_q[WORD_BITS-1:1]};
      end
   end

   generate
      if (OUT_DLY == 0) begin : g_direct
         assign ser_o = sh_q[0];
      end else begin : g_retime
         logic [OUT_DLY-1:0] dly_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               dly_q <= '0;
            else if (bit_en) begin
               dly_q[0] <= sh_q[0];
               for (int i = 1; i < OUT_DLY; i++)
                  dly_q[i] <= dly_q[i-1];
            end
         end
         assign ser_o = dly_q[OUT_DLY-1];
      end
   endgenerate

endmodule

// File: rtl/dual_byte_serializer.sv
module dual_byte_serializer
   import dbs_pkg::*;
#(
   parameter int unsigned LANES   = 2,
   parameter int unsigned OUT_DLY = 16,
   parameter int unsigned ENC_PH  = 14
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bit_en,
   input  logic [LANES*BYTE_BITS-1:0] tx_word,
   input  logic [LANES-1:0]           tx_ctl,
   output logic                       word_take,
   output logic                       ser_out,
   output logic                       k_err
);

   localparam int unsigned DATA_W    = LANES * BYTE_BITS;
   localparam int unsigned WORD_BITS = LANES * SYM_BITS;

   generate
      if (LANES < 1 || LANES > 4) begin : g_bad_lanes
         $error("LANES must be 1 to 4");
      end
      if (ENC_PH + 1 >= WORD_BITS) begin : g_bad_phase
         $error("ENC_PH must fall before the last bit of a word");
      end
      if (OUT_DLY > 64) begin : g_bad_dly
         $error("OUT_DLY must not exceed 64");
      end
   endgenerate

   logic                 enc_fire;
   logic [DATA_W-1:0]    word_q;
   logic [LANES-1:0]     ctl_q;
   logic [WORD_BITS-1:0] enc_d, enc_q;
   logic [LANES:0]       rd_chain;
   logic [LANES-1:0]     k_bad;
   logic                 rd_q;

   dbs_phase #(
      .WORD_BITS (WORD_BITS),
      .ENC_PH    (ENC_PH)
   ) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_en (bit_en),
      .take_o (word_take),
      .enc_o  (enc_fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= {LANES{IDLE_BYTE}};
         ctl_q  <= '1;
      end else if (bit_en && word_take) begin
         word_q <= tx_word;
         ctl_q  <= tx_ctl;
      end
   end

   assign rd_chain[0] = rd_q;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         dbs_byte_enc u_enc (
            .byte_i  (word_q[g*BYTE_BITS +: BYTE_BITS]),
            .k_i     (ctl_q[g]),
            .rd_i    (rd_chain[g]),
            .sym_o   (enc_d[g*SYM_BITS +: SYM_BITS]),
            .rd_o    (rd_chain[g+1]),
            .k_bad_o (k_bad[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enc_q <= '0;
         rd_q  <= 1'b0;
         k_err <= 1'b0;
      end else if (bit_en && enc_fire) begin
         enc_q <= enc_d;
         rd_q  <= rd_chain[LANES];
         if (|k_bad)
            k_err <= 1'b1;
      end
   end

   dbs_shift #(
      .WORD_BITS (WORD_BITS),
      .OUT_DLY   (OUT_DLY)
   ) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_en (bit_en),
      .load_i (word_take),
      .word_i (enc_q),
      .ser_o  (ser_out)
   );

endmodule

// File: rtl/dbs_chk.sv
module dbs_chk #(
   parameter int unsigned WORD_BITS = 20,
   parameter int unsigned OUT_DLY   = 16
) (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic word_take,
   input logic ser_out,
   input logic k_err,
   input logic enc_fire
);

   localparam int unsigned LAT = WORD_BITS + OUT_DLY;
   localparam int unsigned SW  = $clog2(LAT + 1) + 1;
   localparam int unsigned GW  = $clog2(WORD_BITS + 1) + 1;

   logic [SW-1:0] seen_q;
   logic [GW-1:0] gap_q;
   logic [2:0]    run_q;
   logic          live_q, last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= '0;
         gap_q  <= '0;
         run_q  <= '0;
         live_q <= 1'b0;
         last_q <= 1'b0;
      end else if (bit_en) begin
         gap_q <= word_take ? '0 : gap_q + 1'b1;
         if (seen_q < SW'(LAT))
            seen_q <= seen_q + 1'b1;
         else begin
            if (live_q && ser_out == last_q)
               run_q <= (run_q == 3'd7) ? run_q : run_q + 1'b1;
            else
               run_q <= 3'd1;
            live_q <= 1'b1;
            last_q <= ser_out;
         end
      end
   end

   AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && word_take) |=> !word_take);                     // R10

   AST_TAKE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      gap_q < GW'(WORD_BITS));                                     // R10

   AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> ($stable(ser_out) && $stable(word_take)));       // R7

   AST_KERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      k_err |=> k_err);                                            // R9

   AST_KERR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(k_err) |-> $past(enc_fire && bit_en));                 // R9

   AST_RUN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= 3'd5);                                              // R3

endmodule

bind dual_byte_serializer dbs_chk #(
   .WORD_BITS (WORD_BITS),
   .OUT_DLY   (OUT_DLY)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bit_en    (bit_en),
   .word_take (word_take),
   .ser_out   (ser_out),
   .k_err     (k_err),
   .enc_fire  (enc_fire)
);

// File: tb/dual_byte_serializer_tb.sv
module dual_byte_serializer_tb;

   localparam int LAT = 36;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_en = 1'b0;
   logic [15:0] tx_word = 16'h0;
   logic [1:0]  tx_ctl = 2'b00;
   logic        word_take, ser_out, k_err;

   int  n_chk = 0, n_fail = 0;
   int  en_total = 0, since = 0, cap_count = 0;
   bit  prev_en = 0, prev_take = 0, last_ser = 0;
   bit  gap_mode = 0, done = 0, ended = 0;
   bit  rd_m = 0;
   bit  exp_q[$];

   always #10 clk = ~clk;

   dual_byte_serializer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .tx_word   (tx_word),
      .tx_ctl    (tx_ctl),
      .word_take (word_take),
      .ser_out   (ser_out),
      .k_err     (k_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // Reference code tables (negative-disparity column, written abcdei / fghj)
   function automatic logic [5:0] t6(input logic [4:0] x);
      logic [5:0] t [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001,
                             6'b110101, 6'b101001, 6'b011001, 6'b111000,
                             6'b111001, 6'b100101, 6'b010101, 6'b110100,
                             6'b001101, 6'b101100, 6'b011100, 6'b010111,
                             6'b011011, 6'b100011, 6'b010011, 6'b110010,
                             6'b001011, 6'b101010, 6'b011010, 6'b111010,
                             6'b110011, 6'b100110, 6'b010110, 6'b110110,
                             6'b001110, 6'b101110, 6'b011110, 6'b101011};
      return t[x];
   endfunction

   function automatic logic [3:0] t4d(input logic [2:0] y);
      logic [3:0] t [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100,
                            4'b1101, 4'b1010, 4'b0110, 4'b1110};
      return t[y];
   endfunction

   function automatic logic [3:0] t4k(input logic [2:0] y);
      logic [3:0] t [8] = '{4'b1011, 4'b0110, 4'b1010, 4'b1100,
                            4'b1101, 4'b0101, 4'b1001, 4'b0111};
      return t[y];
   endfunction

   // Returns {disparity after, abcdeifghj}
   function automatic logic [10:0] ref_enc(input logic [7:0] b, input logic k, input logic rd);
      logic [4:0] x = b[4:0];
      logic [2:0] y = b[7:5];
      logic kk, r;
      logic [5:0] c6;
      logic [3:0] c4;
      kk = k && (x == 28 || (y == 7 && (x == 23 || x == 27 || x == 29 || x == 30)));
      r  = rd;
      c6 = (kk && x == 28) ? 6'b001111 : t6(x);
      if (r && ($countones(c6) != 3 || c6 == 6'b111000)) c6 = ~c6;
      if ($countones(c6) > 3) r = 1; else if ($countones(c6) < 3) r = 0;
      if (kk && x == 28) begin
         c4 = t4k(y);
         if (r) c4 = ~c4;
      end else begin
         if (y == 7 && (kk || (!r && (x == 17 || x == 18 || x == 20)) ||
                              (r && (x == 11 || x == 13 || x == 14))))
            c4 = 4'b0111;
         else
            c4 = t4d(y);
         if (r && ($countones(c4) != 2 || c4 == 4'b1100)) c4 = ~c4;
      end
      if ($countones(c4) > 2) r = 1; else if ($countones(c4) < 2) r = 0;
      return {r, c6, c4};
   endfunction

   task automatic push_word(input logic [15:0] w, input logic [1:0] c);
      logic [10:0] lo, hi;
      lo = ref_enc(w[7:0], c[0], rd_m);
      hi = ref_enc(w[15:8], c[1], lo[10]);
      rd_m = hi[10];
      for (int i = 9; i >= 0; i--) exp_q.push_back(lo[i]);
      for (int i = 9; i >= 0; i--) exp_q.push_back(hi[i]);
   endtask

   // Driver: called at a negedge; serves the next word slot.
   task automatic send_word(input logic [15:0] w, input logic [1:0] c);
      int c0;
      while (!word_take) @(negedge clk);
      tx_word = w;
      tx_ctl  = c;
      c0 = cap_count;
      wait (cap_count != c0);
      push_word(w, c);
      begin
         logic [31:0] g;
         g = $urandom;
         tx_word = g[15:0];
         tx_ctl  = g[17:16];
      end
   endtask

   // Edge accounting, serial monitor and bit_en pattern, all at the negedge
   always @(negedge clk) begin
      if (!rst_n) begin
         prev_en = 0; prev_take = 0; en_total = 0; since = 0;
         last_ser = ser_out;
         bit_en = 0;
      end else begin
         if (prev_en) begin
            en_total++;
            since++;
            if (prev_take) begin
               chk("R10 word slot spacing", since, 20);
               since = 0;
               cap_count++;
            end
            if (en_total >= LAT) begin
               if (exp_q.size() > 0) begin
                  bit e;
                  e = exp_q.pop_front();
                  chk("R1 R2 R3 R4 R5 R6 R7 serial bit", ser_out, e);
               end else if (!done) begin
                  chk("R6 stream underrun", 1, 0);
               end
            end
         end else begin
            chk("R7 frozen output", ser_out, last_ser);
         end
         last_ser = ser_out;
         bit_en = gap_mode ? (($urandom % 4) != 0) : 1'b1;
         prev_en = bit_en;
         prev_take = word_take;
      end
   end

   initial begin
      repeat (5000 * 40) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R8 reset ser_out", ser_out, 0);
      chk("R8 reset word_take", word_take, 0);
      chk("R8 reset k_err", k_err, 0);
      // First word after reset: K28.5 pair from negative disparity
      push_word(16'hBCBC, 2'b11);
      rst_n = 1'b1;
      @(negedge clk);

      // Directed: D.x.7 forms, alternate x.7, every legal control, all flag pairs
      send_word(16'h0707, 2'b00);
      send_word(16'hF1EB, 2'b00);
      send_word(16'hEBF1, 2'b00);
      send_word(16'hBC1C, 2'b11);
      send_word(16'hFCF7, 2'b11);
      send_word(16'h3CBC, 2'b01);
      send_word(16'hFB00, 2'b10);
      send_word(16'hFEFD, 2'b11);
      send_word(16'h5C7C, 2'b11);
      send_word(16'hDC9C, 2'b11);
      send_word(16'hF4ED, 2'b00);
      send_word(16'h0000, 2'b00);
      send_word(16'hFFFF, 2'b00);
      send_word(16'h5555, 2'b00);
      send_word(16'hAAAA, 2'b00);
      chk("R9 k_err low before illegal control", k_err, 0);
      send_word(16'h0712, 2'b01);
      while (!word_take) @(negedge clk);
      chk("R9 k_err set after illegal control", k_err, 1);
      send_word(16'h12BC, 2'b10);

      for (int n = 0; n < 360; n++) begin
         logic [31:0] r;
         logic [15:0] w;
         logic [1:0]  c;
         if (n == 180) gap_mode = 1;
         r = $urandom;
         w = r[15:0];
         c = 2'b00;
         for (int b = 0; b < 2; b++) begin
            logic [31:0] p;
            p = $urandom;
            if (p[3:0] < 4'd5) begin
               c[b] = 1'b1;
               if (p[7:4] < 4'd8) w[b*8 +: 8] = {p[6:4], 5'd28};
               else case (p[5:4])
                  2'd0: w[b*8 +: 8] = 8'hF7;
                  2'd1: w[b*8 +: 8] = 8'hFB;
                  2'd2: w[b*8 +: 8] = 8'hFD;
                  default: w[b*8 +: 8] = 8'hFE;
               endcase
            end
         end
         send_word(w, c);
      end

      done = 1;
      gap_mode = 0;
      wait (exp_q.size() == 0);
      @(negedge clk);
      chk("R9 k_err sticky", k_err, 1);
      finish_run();
   end

endmodule